// File: doc/BRIEF.md
# Switching Clock Source Selector

This block chooses the timing reference for the PWM of a switching regulator. It runs entirely from a fast system clock. It produces a PWM tick from one of two sources. The first is an internal divider, which is also driven onto a shared sync line in output mode. The second is an external sync clock that the block has qualified and locked to. In auto mode the block looks for an external clock. If none is usable, it runs at one of three fixed rates chosen by a pin strap.

Every enable starts a new qualification. The block measures the spacing of rising edges on the sync input in system clocks. It declares lock after a run of in-range periods. Once locked, each rising edge restarts the PWM cycle. If the external clock stops while locked, the block raises a shutdown request for the power stage and holds it until enable falls. The strap is read once per power-on, at the first enable after reset.

Top module: `sw_clk_select`

## Requirements
- R1: In output mode (mode_i = 2'b00), sync_oe_o is high and the block runs its internal divider as soon as enable is seen, with no edge detection. Freq_code_o is 2. Pwm_tick_o pulses every 312 system clocks. Sync_o is high for 156 cycles starting in the tick cycle and low for the next 156. In all other modes sync_oe_o is low and sync_o stays low.
- R2: In input mode (mode_i = 2'b01) or auto mode (2'b10 or 2'b11), each rising enable starts detection afresh. The first rising edge on sync_i only starts the measurement. Lock is declared on the fourth consecutive in-range period, after which locked_o = 1 and freq_code_o = 4.
- R3: A period is the number of system clocks between two successive rising edges. It is in range when it is between 62 and 625 inclusive. In input mode, an out-of-range period restarts the count of good periods.
- R4: While locked, pwm_tick_o pulses one cycle after each cycle in which sync_i is high after having been low.
- R5: While locked, if 937 cycles pass after the last rising edge with no new edge, locked_o falls and shutdown_o rises. This comes 937 cycles after the tick of that last edge, which is within 10 us at 125 MHz.
- R6: Shutdown_o stays high until en_i falls. Lowering en_i returns every output except sync_oe_o to 0, and the next enable restarts detection.
- R7: In auto mode, the block falls back to its internal divider at the strap frequency if it waits 937 cycles with no edge or sees one out-of-range period. The strap codes are 2'b00 low = 200 kHz (code 1, tick every 625), 2'b01 high = 1 MHz (code 3, every 125), and 2'b10/2'b11 open = 400 kHz (code 2, every 312).
- R8: The strap is captured at the first enable after reset. Later changes of strap_i have no effect until the next reset.
- R9: In auto mode, a valid external clock is locked to exactly as in input mode.
- R10: After reset, pwm_tick_o, sync_o, locked_o, shutdown_o and freq_code_o are 0.
- R11: In input mode with no clock on sync_i, the block waits indefinitely. It raises no tick, no lock and no shutdown.
- R12: No tick is produced in a cycle that follows a cycle with en_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| mode_i | input | 2 | 00 output, 01 input, 1x auto |
| en_i | input | 1 | Regulator enable |
| sync_i | input | 1 | Synchronized sync pin level |
| strap_i | input | 2 | Decoded strap: 00 low, 01 high, 1x open |
| pwm_tick_o | output | 1 | One-cycle PWM cycle start |
| sync_o | output | 1 | Internal clock driven to the sync line |
| sync_oe_o | output | 1 | Output enable for sync_o |
| freq_code_o | output | 3 | 0 none, 1 200 kHz, 2 400 kHz, 3 1 MHz, 4 external |
| locked_o | output | 1 | Locked to the external clock |
| shutdown_o | output | 1 | Request to turn off both power switches |

## Verification
The assertions assume that mode_i does not change while en_i is high. They also assume that sync_i is already synchronous to clk, so a rising edge is simply a high cycle after a low one. The stimulus changes mode and strap only while enable is low or across a reset. It produces sync_i from a divider of the bench clock whose period is set only while the block is disabled, except for deliberate stops that exercise loss of clock.

// File: rtl/sw_clk_select.sv
module sw_clk_select #(
  parameter int SYS_HZ     = 125_000_000,
  parameter int EXT_MIN_HZ = 200_000,
  parameter int EXT_MAX_HZ = 2_000_000,
  parameter int LOW_HZ     = 200_000,
  parameter int MID_HZ     = 400_000,
  parameter int HIGH_HZ    = 1_000_000,
  parameter int LOCK_N     = 4,
  parameter int LOSS_NS    = 7_500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       en_i,
  input  logic       sync_i,
  input  logic [1:0] strap_i,
  output logic       pwm_tick_o,
  output logic       sync_o,
  output logic       sync_oe_o,
  output logic [2:0] freq_code_o,
  output logic       locked_o,
  output logic       shutdown_o
);

  localparam int MAX_P    = SYS_HZ / EXT_MIN_HZ;
  localparam int MIN_P    = SYS_HZ / EXT_MAX_HZ;
  localparam int LOSS_CYC = (SYS_HZ / 1000) * LOSS_NS / 1_000_000;
  localparam int DIV_LOW  = SYS_HZ / LOW_HZ;
  localparam int DIV_MID  = SYS_HZ / MID_HZ;
  localparam int DIV_HIGH = SYS_HZ / HIGH_HZ;
  localparam int CNT_TOP  = (LOSS_CYC > MAX_P) ? LOSS_CYC : MAX_P;
  localparam int CW       = $clog2(CNT_TOP + 2);
  localparam int DW       = $clog2(DIV_LOW + 1);
  localparam int GW       = $clog2(LOCK_N + 1);

  localparam logic [CW-1:0] P_MIN  = CW'(MIN_P);
  localparam logic [CW-1:0] P_MAX  = CW'(MAX_P);
  localparam logic [CW-1:0] P_LOSS = CW'(LOSS_CYC);
  localparam logic [CW-1:0] P_ONE  = CW'(1);
  localparam logic [DW-1:0] HALF_MID = DW'(DIV_MID / 2);
  localparam logic [GW-1:0] G_LAST = GW'(LOCK_N - 1);

  localparam logic [2:0] FC_NONE = 3'd0;
  localparam logic [2:0] FC_LOW  = 3'd1;
  localparam logic [2:0] FC_MID  = 3'd2;
  localparam logic [2:0] FC_HIGH = 3'd3;
  localparam logic [2:0] FC_EXT  = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_DET, S_LOCK, S_SHUT} st_t;

  st_t           st;
  logic          sync_q, tick_q, seen, strap_ok;
  logic [CW-1:0] cnt;
  logic [DW-1:0] div_cnt, reload;
  logic [GW-1:0] good;
  logic [2:0]    run_code, strap_q, strap_now;

  wire rise     = sync_i & ~sync_q;
  wire out_m    = (mode_i == 2'b00);
  wire auto_m   = mode_i[1];
  wire in_range = (cnt >= P_MIN) && (cnt <= P_MAX);
  wire expired  = (cnt >= P_LOSS);

  always_comb begin
    case (strap_i)
      2'b00:   strap_now = FC_LOW;
      2'b01:   strap_now = FC_HIGH;
      default: strap_now = FC_MID;
    endcase
  end

  function automatic logic [DW-1:0] len_of(input logic [2:0] c);
    case (c)
      FC_LOW:  len_of = DW'(DIV_LOW - 1);
      FC_HIGH: len_of = DW'(DIV_HIGH - 1);
      default: len_of = DW'(DIV_MID - 1);
    endcase
  endfunction

  assign reload = len_of(run_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sync_q   <= 1'b0;
      tick_q   <= 1'b0;
      seen     <= 1'b0;
      strap_ok <= 1'b0;
      strap_q  <= FC_MID;
      cnt      <= '0;
      div_cnt  <= '0;
      good     <= '0;
      run_code <= FC_NONE;
    end else begin
      sync_q <= sync_i;
      tick_q <= 1'b0;
      if (st != S_IDLE && !en_i) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (en_i) begin
            if (!strap_ok) begin
              strap_ok <= 1'b1;
              strap_q  <= strap_now;
            end
            if (out_m) begin
              st       <= S_RUN;
              run_code <= FC_MID;
              div_cnt  <= len_of(FC_MID);
            end else begin
              st   <= S_DET;
              cnt  <= P_ONE;
              seen <= 1'b0;
              good <= '0;
            end
          end
          S_RUN: begin
            tick_q  <= (div_cnt == '0);
            div_cnt <= (div_cnt == '0) ? reload : div_cnt - 1'b1;
          end
          S_DET: begin
            if (rise) begin
              cnt  <= P_ONE;
              seen <= 1'b1;
              if (seen) begin
                if (in_range) begin
                  if (good == G_LAST) st <= S_LOCK;
                  else good <= good + 1'b1;
                end else if (auto_m) begin
                  st       <= S_RUN;
                  run_code <= strap_q;
                  div_cnt  <= len_of(strap_q);
                end else begin
                  good <= '0;
                end
              end
            end else if (expired) begin
              if (auto_m) begin
                st       <= S_RUN;
                run_code <= strap_q;
                div_cnt  <= len_of(strap_q);
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_LOCK: begin
            if (rise) begin
              cnt    <= P_ONE;
              tick_q <= 1'b1;
            end else if (expired) begin
              st <= S_SHUT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign pwm_tick_o  = tick_q;
  assign sync_oe_o   = out_m;
  assign sync_o      = out_m && (st == S_RUN) && (div_cnt >= HALF_MID);
  assign locked_o    = (st == S_LOCK);
  assign shutdown_o  = (st == S_SHUT);
  assign freq_code_o = (st == S_LOCK) ? FC_EXT : (st == S_RUN) ? run_code : FC_NONE;

endmodule

// File: rtl/sw_clk_select_chk.sv
module sw_clk_select_chk #(
  parameter int SYS_HZ  = 125_000_000,
  parameter int LOSS_NS = 7_500
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       sync_i,
  input logic       pwm_tick_o,
  input logic       sync_o,
  input logic       sync_oe_o,
  input logic [2:0] freq_code_o,
  input logic       locked_o,
  input logic       shutdown_o
);
  localparam int LOSS_CYC = (SYS_HZ / 1000) * LOSS_NS / 1_000_000;

  logic        s1, s2;
  logic [15:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= 1'b0;
      s2  <= 1'b0;
      gap <= '0;
    end else begin
      s1  <= sync_i;
      s2  <= s1;
      gap <= (sync_i && !s1) ? 16'd1 : ((gap == 16'hFFFF) ? gap : gap + 16'd1);
    end
  end

  p_sync_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_oe_o |-> !sync_o);

  p_tick_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_tick_o && locked_o) |-> (s1 && !s2));

  p_loss_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> (gap <= 16'(LOSS_CYC)));

  p_shut_after_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown_o) |-> $past(locked_o));

  p_shut_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_o && en_i) |=> shutdown_o);

  p_freq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_i) && $past(freq_code_o) != 3'd0 && $past(freq_code_o) != 3'd4)
      |-> $stable(freq_code_o));

  p_tick_needs_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_tick_o |-> $past(en_i));

endmodule

bind sw_clk_select sw_clk_select_chk #(.SYS_HZ(SYS_HZ), .LOSS_NS(LOSS_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .sync_i(sync_i),
  .pwm_tick_o(pwm_tick_o), .sync_o(sync_o), .sync_oe_o(sync_oe_o),
  .freq_code_o(freq_code_o), .locked_o(locked_o), .shutdown_o(shutdown_o)
);

// File: tb/tb_sw_clk_select.sv
`timescale 1ns/1ps
module tb_sw_clk_select;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_i = 2'b01;
  logic       en_i = 1'b0;
  logic       sync_i = 1'b0;
  logic [1:0] strap_i = 2'b00;
  logic       pwm_tick_o, sync_o, sync_oe_o, locked_o, shutdown_o;
  logic [2:0] freq_code_o;

  sw_clk_select dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .en_i(en_i), .sync_i(sync_i),
    .strap_i(strap_i), .pwm_tick_o(pwm_tick_o), .sync_o(sync_o),
    .sync_oe_o(sync_oe_o), .freq_code_o(freq_code_o), .locked_o(locked_o),
    .shutdown_o(shutdown_o)
  );

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // sync clock source
  int sper = 0;
  int ph = 0;
  always @(negedge clk) begin
    if (sper == 0) begin
      sync_i <= 1'b0;
      ph = 0;
    end else begin
      sync_i <= (ph < sper / 2);
      ph = (ph + 1) % sper;
    end
  end

  // behavioural reference
  int  ms, gap, good, phase, code, scode;
  bit  seen, etick, sset, prev, r;

  function automatic int len_for(input int c);
    return (c == 1) ? 625 : (c == 3) ? 125 : 312;
  endfunction

  task automatic fall_back();
    ms = 1; code = scode; phase = len_for(scode) - 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; gap = 0; good = 0; phase = 0; code = 0; scode = 2;
      seen = 0; etick = 0; sset = 0; prev = 0;
    end else begin
      r = sync_i && !prev;
      prev = sync_i;
      etick = 0;
      if (ms != 0 && !en_i) ms = 0;
      else begin
        case (ms)
          0: if (en_i) begin
            if (!sset) begin
              sset = 1;
              scode = (strap_i == 2'b00) ? 1 : (strap_i == 2'b01) ? 3 : 2;
            end
            if (mode_i == 2'b00) begin ms = 1; code = 2; phase = 311; end
            else begin ms = 2; gap = 1; seen = 0; good = 0; end
          end
          1: if (phase == 0) begin etick = 1; phase = len_for(code) - 1; end
             else phase--;
          2: if (r) begin
            if (seen) begin
              if (gap >= 62 && gap <= 625) begin
                good++;
                if (good == 4) ms = 3;
              end else if (mode_i[1]) fall_back();
              else good = 0;
            end
            seen = 1; gap = 1;
          end else if (gap >= 937) begin
            if (mode_i[1]) fall_back();
          end else gap++;
          3: if (r) begin etick = 1; gap = 1; end
             else if (gap >= 937) ms = 4;
             else gap++;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison and monitors
  int cyc = 0, last_tick = 0, tick_gap = 0, ticks = 0, shut_rise = 0;
  bit shut_prev = 0;
  initial forever begin
    @(posedge clk);
    #2;
    cyc++;
    if (rst_n) begin
      int ef;
      bit es;
      ef = (ms == 3) ? 4 : (ms == 1) ? code : 0;
      es = (mode_i == 2'b00) && (ms == 1) && (phase >= 156);
      nchk++;
      if (pwm_tick_o !== etick || locked_o !== (ms == 3) || shutdown_o !== (ms == 4) ||
          freq_code_o !== 3'(ef) || sync_o !== es || sync_oe_o !== (mode_i == 2'b00)) begin
        nfail++;
        $display("FAIL R4/R5/R7/R1 cycle %0d actual tick=%0b lock=%0b shut=%0b freq=%0d sync=%0b expected tick=%0b lock=%0b shut=%0b freq=%0d sync=%0b",
                 cyc, pwm_tick_o, locked_o, shutdown_o, freq_code_o, sync_o,
                 etick, ms == 3, ms == 4, ef, es);
      end
      if (pwm_tick_o) begin
        tick_gap = cyc - last_tick;
        last_tick = cyc;
        ticks++;
      end
      if (shutdown_o && !shut_prev) shut_rise = cyc;
      shut_prev = shutdown_o;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en_i = 1'b0; sper = 0;
    cycles(4);
    rst_n = 1'b1;
    cycles(2);
  endtask

  task automatic disable_en();
    @(negedge clk);
    en_i = 1'b0;
    cycles(3);
  endtask

  task automatic ext_try(input logic [1:0] m, input int per, input int wait_n);
    disable_en();
    mode_i = m; sper = per;
    cycles(per * 2 + 4);
    en_i = 1'b1;
    cycles(wait_n);
  endtask

  initial begin
    do_reset();
    // R10 reset state
    chk("R10 tick after reset", pwm_tick_o, 0);
    chk("R10 lock after reset", locked_o, 0);
    chk("R10 shutdown after reset", shutdown_o, 0);
    chk("R10 freq after reset", freq_code_o, 0);
    chk("R10 sync_o after reset", sync_o, 0);

    // R1 output mode, strap low captured here (R8)
    mode_i = 2'b00; strap_i = 2'b00; en_i = 1'b1;
    cycles(2000);
    chk("R1 oe in output mode", sync_oe_o, 1);
    chk("R1 freq code", freq_code_o, 2);
    chk("R1 tick spacing", tick_gap, 312);
    chk("R1 no lock", locked_o, 0);

    // R12 / R6 disable
    disable_en();
    ticks = 0;
    cycles(700);
    chk("R12 no ticks while disabled", ticks, 0);
    chk("R6 freq cleared when disabled", freq_code_o, 0);

    // R11 input mode without clock
    mode_i = 2'b01; strap_i = 2'b01;
    chk("R1 oe low outside output mode", sync_oe_o, 0);
    en_i = 1'b1;
    cycles(3000);
    chk("R11 no lock without clock", locked_o, 0);
    chk("R11 no shutdown without clock", shutdown_o, 0);
    chk("R11 no ticks without clock", ticks, 0);

    // R2 lock on 400-cycle clock, not early
    ext_try(2'b01, 400, 1300);
    chk("R2 not locked before four periods", locked_o, 0);
    cycles(1400);
    chk("R2 locked after four periods", locked_o, 1);
    chk("R2 external freq code", freq_code_o, 4);
    cycles(900);
    chk("R4 tick follows edges", tick_gap, 400);

    // R5 loss of clock
    @(negedge clk);
    sper = 0;
    cycles(1300);
    chk("R5 shutdown raised", shutdown_o, 1);
    chk("R5 lock dropped", locked_o, 0);
    chk("R5 shutdown delay from last tick", shut_rise - last_tick, 937);
    cycles(2000);
    chk("R6 shutdown held while enabled", shutdown_o, 1);
    disable_en();
    chk("R6 shutdown cleared by disable", shutdown_o, 0);

    // R6 restart after shutdown
    ext_try(2'b01, 300, 2200);
    chk("R6 relock after new enable", locked_o, 1);

    // R3 boundaries
    ext_try(2'b01, 61, 1500);
    chk("R3 period 61 rejected", locked_o, 0);
    chk("R3 no shutdown on fast clock", shutdown_o, 0);
    ext_try(2'b01, 62, 600);
    chk("R3 period 62 accepted", locked_o, 1);
    ext_try(2'b01, 625, 3600);
    chk("R3 period 625 accepted", locked_o, 1);
    ext_try(2'b01, 626, 5000);
    chk("R3 period 626 rejected", locked_o, 0);

    // R7 / R8 auto fallback uses strap captured at first enable (low)
    strap_i = 2'b01;
    ext_try(2'b10, 0, 1200);
    chk("R8 strap change ignored", freq_code_o, 1);
    cycles(1500);
    chk("R7 fallback tick spacing 625", tick_gap, 625);
    chk("R7 no lock in fallback", locked_o, 0);

    // R7 out-of-range period in auto mode
    ext_try(2'b10, 700, 2200);
    chk("R7 slow clock falls back", freq_code_o, 1);

    // R9 auto mode with valid clock
    ext_try(2'b11, 100, 800);
    chk("R9 auto locks", locked_o, 1);
    chk("R9 auto external code", freq_code_o, 4);

    // R7 strap mapping after new power-on
    strap_i = 2'b10;
    do_reset();
    mode_i = 2'b10; en_i = 1'b1;
    cycles(1500);
    chk("R7 open strap gives 400k", freq_code_o, 2);
    strap_i = 2'b01;
    do_reset();
    mode_i = 2'b10; en_i = 1'b1;
    cycles(1500);
    chk("R7 high strap gives 1M", freq_code_o, 3);
    chk("R7 high strap tick spacing", tick_gap, 125);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule